// File: doc/BRIEF.md
# Edge-Pulse Isolation Channel Codec

This block carries one logic level across a barrier that only passes short pulses. The transmit half samples a single input and, on each transition, emits a one-cycle pulse on a set line (input went high) or a clear line (input went low). While the input stays steady, it re-sends a pulse that matches the current level once every refresh interval. This refresh keeps a long, static level correct at the far side.

The receive half is a bistable latch that the pulses drive. A watchdog counts the cycles that pass with no pulse. If that count reaches its limit, the watchdog forces the output to a fixed default level and raises a status flag. The first pulse after a timeout clears the flag and restores normal tracking.

Both halves run on one clock. The transmit pulse lines and the receive pulse inputs are separate ports, so the surrounding logic (or a bench) wires the barrier between them. WATCHDOG_CYCLES must be greater than REFRESH_CYCLES. The top module rejects any other setting at elaboration.

Top module: `epl_link`

## Requirements
- R1: When the input rises, tx_set_o is high for exactly the one cycle after the clock edge that sampled the new level. When the input falls, tx_clr_o does the same.
- R2: Every transmitted pulse is one cycle wide, and tx_set_o and tx_clr_o are never high in the same cycle.
- R3: When the input holds steady, a refresh pulse matching the input level is sent REFRESH_CYCLES cycles after the previous pulse. It repeats every REFRESH_CYCLES cycles: tx_set_o if the level is 1, tx_clr_o if it is 0.
- R4: An input edge restarts the refresh count. No pulse appears in the REFRESH_CYCLES-1 cycles after an edge pulse, and the next refresh comes exactly REFRESH_CYCLES cycles after it.
- R5: The cycle after rx_set_i alone is sampled, rx_level_o is 1. The cycle after rx_clr_i alone is sampled, rx_level_o is 0. With no pulse, rx_level_o holds.
- R6: During and after reset, rx_level_o equals DEFAULT_OUT (1 by default), and rx_lost_o, rx_collide_o, tx_set_o and tx_clr_o are all 0.
- R7: Suppose the last receive pulse was sampled at clock edge p and no further pulse arrives. Then rx_lost_o rises and rx_level_o takes DEFAULT_OUT after edge p+WATCHDOG_CYCLES. Both stay that way until a pulse arrives.
- R8: Any received pulse restarts the watchdog count. The cycle after the first pulse following a timeout, rx_lost_o is 0 and rx_level_o reflects that pulse.
- R9: If rx_set_i and rx_clr_i are sampled high together, rx_level_o keeps its value and rx_collide_o is high for the following cycle only. This event still counts as activity for the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both halves |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_level_i | input | 1 | Logic level to be carried |
| tx_set_o | output | 1 | One-cycle pulse: level is high |
| tx_clr_o | output | 1 | One-cycle pulse: level is low |
| rx_set_i | input | 1 | Received set pulse |
| rx_clr_i | input | 1 | Received clear pulse |
| rx_level_o | output | 1 | Reconstructed level |
| rx_lost_o | output | 1 | High while the watchdog has expired |
| rx_collide_o | output | 1 | One-cycle flag: set and clear arrived together |

## Verification
A healthy loop never starves the receiver and never delivers set and clear together, so neither the timeout nor the collision path can be reached by driving the input alone. The bench places a gate in the pulse path between the transmitter and the receiver.

For the timeout, the bench closes the gate on the cycle right after a refresh pulse is sampled, which gives an exact start for counting toward the expiry edge. It then reopens the gate and waits for the next refresh to confirm recovery. For the collision, the bench injects a set and a clear together while the latch holds 0, so a set-priority fault would show as a 1 on the output.

// File: rtl/epl_pkg.sv
package epl_pkg;
    typedef struct packed {
        logic set;
        logic clr;
    } pulse_pair_t;
endpackage

// File: rtl/epl_edge_encoder.sv
module epl_edge_encoder
    import epl_pkg::*;
#(
    parameter int REFRESH_CYCLES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        level_i,
    output pulse_pair_t pulse_o
);
    localparam int CW = $clog2(REFRESH_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(REFRESH_CYCLES - 1);

    typedef struct packed {
        logic          lvl;
        pulse_pair_t   pulse;
        logic [CW-1:0] cnt;
    } enc_state_t;

    enc_state_t enc_d, enc_q;

    always_comb begin
        enc_d           = enc_q;
        enc_d.lvl       = level_i;
        enc_d.pulse.set = 1'b0;
        enc_d.pulse.clr = 1'b0;
        if (level_i != enc_q.lvl) begin
            enc_d.pulse.set = level_i;
            enc_d.pulse.clr = !level_i;
            enc_d.cnt       = '0;
        end else if (enc_q.cnt == LAST) begin
            enc_d.pulse.set = enc_q.lvl;
            enc_d.pulse.clr = !enc_q.lvl;
            enc_d.cnt       = '0;
        end else begin
            enc_d.cnt = enc_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) enc_q <= '0;
        else        enc_q <= enc_d;
    end

    assign pulse_o = enc_q.pulse;

    // R2
    pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(enc_q.pulse.set && enc_q.pulse.clr));

    // R2
    set_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enc_q.pulse.set |=> !enc_q.pulse.set);

    // R2
    clr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enc_q.pulse.clr |=> !enc_q.pulse.clr);

    // R3
    refresh_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enc_q.cnt < CW'(REFRESH_CYCLES));
endmodule

// File: rtl/epl_watchdog.sv
module epl_watchdog #(
    parameter int WATCHDOG_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic activity_i,
    output logic expire_o,
    output logic lost_o
);
    localparam int CW = $clog2(WATCHDOG_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WATCHDOG_CYCLES - 1);

    typedef struct packed {
        logic          lost;
        logic [CW-1:0] cnt;
    } wd_state_t;

    wd_state_t wd_d, wd_q;

    always_comb begin
        wd_d = wd_q;
        if (activity_i) begin
            wd_d.cnt  = '0;
            wd_d.lost = 1'b0;
        end else if (wd_q.cnt == LAST) begin
            wd_d.lost = 1'b1;
        end else begin
            wd_d.cnt = wd_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wd_q <= '0;
        else        wd_q <= wd_d;
    end

    assign expire_o = !activity_i && (wd_q.cnt == LAST);
    assign lost_o   = wd_q.lost;

    // R7
    lost_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_q.lost && !activity_i) |=> wd_q.lost);

    // R8
    lost_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        activity_i |=> !wd_q.lost);
endmodule

// File: rtl/epl_bistable_rx.sv
module epl_bistable_rx
    import epl_pkg::*;
#(
    parameter bit DEFAULT_OUT = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  pulse_pair_t pulse_i,
    input  logic        force_i,
    output logic        level_o,
    output logic        collide_o
);
    typedef struct packed {
        logic level;
        logic collide;
    } rx_state_t;

    rx_state_t rx_d, rx_q;

    always_comb begin
        rx_d         = rx_q;
        rx_d.collide = 1'b0;
        if (pulse_i.set && pulse_i.clr) begin
            rx_d.collide = 1'b1;
        end else if (pulse_i.set) begin
            rx_d.level = 1'b1;
        end else if (pulse_i.clr) begin
            rx_d.level = 1'b0;
        end else if (force_i) begin
            rx_d.level = DEFAULT_OUT;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q.level   <= DEFAULT_OUT;
            rx_q.collide <= 1'b0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign level_o   = rx_q.level;
    assign collide_o = rx_q.collide;

    // R9
    collide_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_i.set && pulse_i.clr) |=> $stable(rx_q.level));

    // R5
    set_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_i.set && !pulse_i.clr) |=> rx_q.level);

    // R5
    clr_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_i.clr && !pulse_i.set) |=> !rx_q.level);

    // R7
    force_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_i && !pulse_i.set && !pulse_i.clr) |=> (rx_q.level == DEFAULT_OUT));
endmodule

// File: rtl/epl_link.sv
module epl_link
    import epl_pkg::*;
#(
    parameter int REFRESH_CYCLES  = 8,
    parameter int WATCHDOG_CYCLES = 40,
    parameter bit DEFAULT_OUT     = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_level_i,
    output logic tx_set_o,
    output logic tx_clr_o,
    input  logic rx_set_i,
    input  logic rx_clr_i,
    output logic rx_level_o,
    output logic rx_lost_o,
    output logic rx_collide_o
);
    generate
        if (WATCHDOG_CYCLES <= REFRESH_CYCLES || REFRESH_CYCLES < 2) begin : g_bad_cfg
            $error("epl_link: need WATCHDOG_CYCLES > REFRESH_CYCLES >= 2");
        end
    endgenerate

    pulse_pair_t tx_pulse;
    pulse_pair_t rx_pulse;
    logic        wd_expire;

    assign rx_pulse.set = rx_set_i;
    assign rx_pulse.clr = rx_clr_i;

    epl_edge_encoder #(.REFRESH_CYCLES(REFRESH_CYCLES)) enc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (tx_level_i),
        .pulse_o (tx_pulse)
    );

    epl_watchdog #(.WATCHDOG_CYCLES(WATCHDOG_CYCLES)) wd_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .activity_i (rx_set_i || rx_clr_i),
        .expire_o   (wd_expire),
        .lost_o     (rx_lost_o)
    );

    epl_bistable_rx #(.DEFAULT_OUT(DEFAULT_OUT)) rx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pulse_i   (rx_pulse),
        .force_i   (wd_expire),
        .level_o   (rx_level_o),
        .collide_o (rx_collide_o)
    );

    assign tx_set_o = tx_pulse.set;
    assign tx_clr_o = tx_pulse.clr;

    // R7
    lost_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_lost_o |-> (rx_level_o == DEFAULT_OUT));
endmodule

// File: tb/epl_link_tb_top.sv
`timescale 1ns/1ps
module epl_link_tb_top;
    localparam int RC = 8;
    localparam int WC = 40;
    localparam bit DEF = 1'b1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din = 1'b0;
    logic cut = 1'b0;
    logic inj_set = 1'b0;
    logic inj_clr = 1'b0;
    logic tx_set, tx_clr, rx_level, rx_lost, rx_collide;
    logic rx_set, rx_clr;
    int   n_run = 0;
    int   n_fail = 0;

    always #2.5 clk = ~clk;

    assign rx_set = (tx_set & ~cut) | inj_set;
    assign rx_clr = (tx_clr & ~cut) | inj_clr;

    epl_link #(.REFRESH_CYCLES(RC), .WATCHDOG_CYCLES(WC), .DEFAULT_OUT(DEF)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_level_i   (din),
        .tx_set_o     (tx_set),
        .tx_clr_o     (tx_clr),
        .rx_set_i     (rx_set),
        .rx_clr_i     (rx_clr),
        .rx_level_o   (rx_level),
        .rx_lost_o    (rx_lost),
        .rx_collide_o (rx_collide)
    );

    // {din, cycles to wait, expected rx_level}
    localparam logic [9:0] VEC [8] = '{
        {1'b1, 8'd2,  1'b1},
        {1'b0, 8'd2,  1'b0},
        {1'b1, 8'd3,  1'b1},
        {1'b0, 8'd12, 1'b0},
        {1'b1, 8'd20, 1'b1},
        {1'b0, 8'd5,  1'b0},
        {1'b1, 8'd2,  1'b1},
        {1'b0, 8'd30, 1'b0}
    };

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R6 reset state
        chk("R6 level", rx_level, DEF);
        chk("R6 lost", rx_lost, 1'b0);
        chk("R6 tx", tx_set | tx_clr, 1'b0);
        chk("R6 collide", rx_collide, 1'b0);
        rst_n = 1'b1;

        // R1 rising edge pulse, R4 quiet gap, R3 refresh
        @(negedge clk); din = 1'b1;
        @(negedge clk);
        chk("R1 set pulse", tx_set, 1'b1);
        chk("R2 no clr", tx_clr, 1'b0);
        for (int i = 1; i < RC; i++) begin
            @(negedge clk);
            chk("R4 quiet after edge", tx_set | tx_clr, 1'b0);
        end
        @(negedge clk);
        chk("R3 refresh set", tx_set, 1'b1);
        chk("R5 level high", rx_level, 1'b1);
        for (int i = 1; i < RC; i++) @(negedge clk);
        @(negedge clk);
        chk("R3 refresh repeat", tx_set, 1'b1);

        // R1 falling edge
        din = 1'b0;
        @(negedge clk);
        chk("R1 clr pulse", tx_clr, 1'b1);
        chk("R2 no set", tx_set, 1'b0);
        @(negedge clk);
        chk("R2 clr width", tx_clr, 1'b0);
        chk("R5 level low", rx_level, 1'b0);

        // R5 table of level patterns
        for (int v = 0; v < 8; v++) begin
            din = VEC[v][9];
            repeat (int'(VEC[v][8:1])) @(negedge clk);
            chk("R5 table", rx_level, VEC[v][0]);
        end

        // R8 refresh keeps watchdog from expiring
        din = 1'b1;
        repeat (3 * WC) @(negedge clk);
        chk("R8 no timeout", rx_lost, 1'b0);
        chk("R3 level kept", rx_level, 1'b1);

        // R7 timeout with input low
        din = 1'b0;
        repeat (3) @(negedge clk);
        while (!tx_clr) @(negedge clk);
        @(posedge clk); #1 cut = 1'b1;
        for (int j = 1; j <= WC; j++) @(negedge clk);
        chk("R7 not yet lost", rx_lost, 1'b0);
        chk("R7 level before", rx_level, 1'b0);
        @(negedge clk);
        chk("R7 lost", rx_lost, 1'b1);
        chk("R7 default", rx_level, DEF);
        repeat (5) @(negedge clk);
        chk("R7 lost held", rx_lost, 1'b1);

        // R8 recovery
        cut = 1'b0;
        @(negedge clk);
        while (!tx_clr) @(negedge clk);
        @(negedge clk);
        chk("R8 lost cleared", rx_lost, 1'b0);
        chk("R8 level restored", rx_level, 1'b0);

        // R9 collision while low
        inj_set = 1'b1; inj_clr = 1'b1;
        @(negedge clk);
        inj_set = 1'b0; inj_clr = 1'b0;
        chk("R9 collide flag", rx_collide, 1'b1);
        chk("R9 level held", rx_level, 1'b0);
        @(negedge clk);
        chk("R9 flag one cycle", rx_collide, 1'b0);
        chk("R9 level still", rx_level, 1'b0);

        // R5 lone injected set
        inj_set = 1'b1;
        @(negedge clk);
        inj_set = 1'b0;
        chk("R5 injected set", rx_level, 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule